// File: doc/BRIEF.md
# Strobed External Data Port Register

This block is one socket's slice of a host adapter's register file. It holds an 8-bit data register that software reaches through an index/data port pair on an ISA-style I/O bus. The data register acts in one of three ways, and a two-bit mode field in a companion control register picks which. It can be a plain scratchpad. It can be a read window onto external logic, where a strobe pin enables an external buffer onto the upper data byte. It can be a write latch, where a strobe pin tells external logic to capture the upper data byte.

Software first writes a primary index to port 0. Port 1 then reaches the selected register. Primary index 2Eh makes port 1 the extended-index register. Primary index 2Fh makes port 1 the extended register that the extended index names. The strobe pin is combinational. It follows the I/O read or I/O write command only while that command targets the data register in the matching mode.

Top module: `xd_ext_port`

## Requirements
- R1: After reset the primary index, extended index, control and data registers all read 0, and `gp_strobe` and `rd_oe` are low.
- R2: Port 0 (`port_sel`=0) reads and writes the primary index. With primary index 2Eh, port 1 reads and writes the extended index. With primary index 2Fh, port 1 reaches the data register at extended index 0Ah and the control register at extended index 0Bh. Any other combination reads 0, and writes to it are ignored.
- R3: With control bits 4 and 3 both 0 (scratchpad), a data write is stored, a data read returns the stored value, and `gp_strobe` stays low.
- R4: With only control bit 3 set (read port), `gp_strobe` is high while `cs` is high and `ior_n` is low on a data-register read, and the readback equals `ext_rdata`. Data writes in this mode are still stored.
- R5: A read in read-port mode leaves the stored data value unchanged. It can be seen again once the mode returns to scratchpad.
- R6: With only control bit 4 set (write port), `gp_strobe` is high while `cs` is high and `iow_n` is low on a data-register write, the written value is stored, and reads return it with `gp_strobe` low.
- R7: With control bits 4 and 3 both set (reserved), `gp_strobe` never rises and the data register behaves as a scratchpad.
- R8: `gp_strobe` is never high unless `cs` is high, a command is active, and the index pair selects the data register. Accesses to any other register leave it low.
- R9: Control bits other than 3 and 4 are stored and read back, and they have no effect on the mode.
- R10: A write takes effect once per command, at the first clock edge where `cs` is high and `iow_n` is low. A write with `cs` low changes nothing.
- R11: `rd_oe` is high exactly while `cs` is high and `ior_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Address decode hit for this port pair |
| port_sel | input | 1 | 0 selects the index port, 1 selects the data port |
| ior_n | input | 1 | Active-low I/O read command |
| iow_n | input | 1 | Active-low I/O write command |
| wdata | input | DW | Host write data (low byte) |
| ext_rdata | input | DW | External data presented on the upper byte in read-port mode |
| rdata | output | DW | Register readback |
| rd_oe | output | 1 | Readback drive enable for the host data bus |
| gp_strobe | output | 1 | Active-high general-purpose strobe to external logic |

## Verification
On every cycle, the assertions check these properties:
- the strobe is silent in scratchpad and reserved modes;
- the strobe never rises without an active command aimed at the data register, and it follows that command in the read-port and write-port modes;
- read-port readback mirrors the external input;
- reads never disturb the stored data;
- a committed data write lands in the register;
- the drive enable never rises without a read.

Other behaviours can only be shown by the bench's scenarios. These are the reset values seen through the ports, the index decode for unmapped pairs, ignored writes with `cs` low, and the read-back of the unused control bits. The same holds for the stored value surviving a read-port episode, which becomes visible only after a mode change.

// File: rtl/xd_pkg.sv
`timescale 1ns/1ps
package xd_pkg;

   typedef enum logic [1:0] {
      XD_SCRATCH  = 2'b00,
      XD_RDPORT   = 2'b01,
      XD_WRPORT   = 2'b10,
      XD_RESERVED = 2'b11
   } xd_mode_e;

   function automatic xd_mode_e xd_decode_mode(input logic wr_en_bit, input logic rd_en_bit);
      xd_mode_e m;
      case ({wr_en_bit, rd_en_bit})
         2'b01:   m = XD_RDPORT;
         2'b10:   m = XD_WRPORT;
         2'b11:   m = XD_RESERVED;
         default: m = XD_SCRATCH;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/xd_index_decode.sv
`timescale 1ns/1ps
module xd_index_decode #(
   parameter int            DW         = 8,
   parameter logic [DW-1:0] PIDX_XIDX  = 8'h2E,
   parameter logic [DW-1:0] PIDX_XDATA = 8'h2F,
   parameter logic [DW-1:0] XIDX_DATA  = 8'h0A,
   parameter logic [DW-1:0] XIDX_CTRL  = 8'h0B
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_pulse,
   input  logic          port_sel,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] pidx_q,
   output logic [DW-1:0] xidx_q,
   output logic          sel_xidx,
   output logic          sel_data,
   output logic          sel_ctrl
);

   generate
      if (PIDX_XIDX == PIDX_XDATA) begin : g_bad_pidx
         $error("xd_index_decode: primary index codes must differ");
      end
      if (XIDX_DATA == XIDX_CTRL) begin : g_bad_xidx
         $error("xd_index_decode: extended index codes must differ");
      end
   endgenerate

   logic at_xdata;

   assign at_xdata = port_sel && (pidx_q == PIDX_XDATA);
   assign sel_xidx = port_sel && (pidx_q == PIDX_XIDX);
   assign sel_data = at_xdata && (xidx_q == XIDX_DATA);
   assign sel_ctrl = at_xdata && (xidx_q == XIDX_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pidx_q <= '0;
         xidx_q <= '0;
      end else if (wr_pulse) begin
         if (!port_sel) pidx_q <= wdata;
         else if (sel_xidx) xidx_q <= wdata;
      end
   end

endmodule

// File: rtl/xd_mode_ctrl.sv
`timescale 1ns/1ps
module xd_mode_ctrl
   import xd_pkg::*;
#(
   parameter int DW     = 8,
   parameter int RD_BIT = 3,
   parameter int WR_BIT = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] ctrl_q,
   output xd_mode_e      mode
);

   generate
      if (RD_BIT == WR_BIT) begin : g_bad_same
         $error("xd_mode_ctrl: read and write strobe bits must differ");
      end
      if (RD_BIT >= DW || WR_BIT >= DW || RD_BIT < 0 || WR_BIT < 0) begin : g_bad_range
         $error("xd_mode_ctrl: strobe enable bits must lie inside the register");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ctrl_q <= '0;
      else if (wr_en) ctrl_q <= wdata;
   end

   assign mode = xd_decode_mode(ctrl_q[WR_BIT], ctrl_q[RD_BIT]);

endmodule

// File: rtl/xd_data_port.sv
`timescale 1ns/1ps
module xd_data_port
   import xd_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          rd_cmd,
   input  logic          wr_cmd,
   input  xd_mode_e      mode,
   input  logic [DW-1:0] wdata,
   input  logic [DW-1:0] ext_rdata,
   output logic [DW-1:0] data_q,
   output logic [DW-1:0] port_rdata,
   output logic          gp_strobe
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     data_q <= '0;
      else if (wr_en) data_q <= wdata;
   end

   always_comb begin
      gp_strobe  = 1'b0;
      port_rdata = data_q;
      unique case (mode)
         XD_RDPORT: begin
            gp_strobe  = rd_cmd;
            port_rdata = ext_rdata;
         end
         XD_WRPORT: gp_strobe = wr_cmd;
         default:   gp_strobe = 1'b0;
      endcase
   end

endmodule

// File: rtl/xd_ext_port.sv
`timescale 1ns/1ps
module xd_ext_port
   import xd_pkg::*;
#(
   parameter int            DW         = 8,
   parameter logic [DW-1:0] PIDX_XIDX  = 8'h2E,
   parameter logic [DW-1:0] PIDX_XDATA = 8'h2F,
   parameter logic [DW-1:0] XIDX_DATA  = 8'h0A,
   parameter logic [DW-1:0] XIDX_CTRL  = 8'h0B,
   parameter int            RD_BIT     = 3,
   parameter int            WR_BIT     = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs,
   input  logic          port_sel,
   input  logic          ior_n,
   input  logic          iow_n,
   input  logic [DW-1:0] wdata,
   input  logic [DW-1:0] ext_rdata,
   output logic [DW-1:0] rdata,
   output logic          rd_oe,
   output logic          gp_strobe
);

   localparam logic [DW-1:0] UNMAPPED = '0;

   generate
      if (DW < 2) begin : g_bad_dw
         $error("xd_ext_port: data width too small");
      end
   endgenerate

   logic          iow_q;
   logic          wr_pulse;
   logic          rd_cmd;
   logic          wr_cmd;
   logic [DW-1:0] pidx_q;
   logic [DW-1:0] xidx_q;
   logic          sel_xidx;
   logic          sel_data;
   logic          sel_ctrl;
   logic [DW-1:0] ctrl_q;
   xd_mode_e      mode;
   logic [DW-1:0] data_q;
   logic [DW-1:0] port_rdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) iow_q <= 1'b1;
      else        iow_q <= iow_n;
   end

   assign wr_pulse = cs && !iow_n && iow_q;
   assign rd_cmd   = cs && !ior_n && sel_data;
   assign wr_cmd   = cs && !iow_n && sel_data;
   assign rd_oe    = cs && !ior_n;

   xd_index_decode #(
      .DW(DW), .PIDX_XIDX(PIDX_XIDX), .PIDX_XDATA(PIDX_XDATA),
      .XIDX_DATA(XIDX_DATA), .XIDX_CTRL(XIDX_CTRL)
   ) i_index (
      .clk(clk), .rst_n(rst_n), .wr_pulse(wr_pulse), .port_sel(port_sel),
      .wdata(wdata), .pidx_q(pidx_q), .xidx_q(xidx_q),
      .sel_xidx(sel_xidx), .sel_data(sel_data), .sel_ctrl(sel_ctrl)
   );

   xd_mode_ctrl #(.DW(DW), .RD_BIT(RD_BIT), .WR_BIT(WR_BIT)) i_mode (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_pulse && sel_ctrl),
      .wdata(wdata), .ctrl_q(ctrl_q), .mode(mode)
   );

   xd_data_port #(.DW(DW)) i_data (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_pulse && sel_data),
      .rd_cmd(rd_cmd), .wr_cmd(wr_cmd), .mode(mode), .wdata(wdata),
      .ext_rdata(ext_rdata), .data_q(data_q), .port_rdata(port_rdata),
      .gp_strobe(gp_strobe)
   );

   always_comb begin
      if (!port_sel)     rdata = pidx_q;
      else if (sel_xidx) rdata = xidx_q;
      else if (sel_data) rdata = port_rdata;
      else if (sel_ctrl) rdata = ctrl_q;
      else               rdata = UNMAPPED;
   end

endmodule

// File: rtl/xd_ext_port_chk.sv
`timescale 1ns/1ps
module xd_ext_port_chk #(
   parameter int DW     = 8,
   parameter int RD_BIT = 3,
   parameter int WR_BIT = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cs,
   input logic          ior_n,
   input logic          iow_n,
   input logic [DW-1:0] wdata,
   input logic [DW-1:0] ext_rdata,
   input logic [DW-1:0] rdata,
   input logic          rd_oe,
   input logic          gp_strobe,
   input logic          sel_data,
   input logic          wr_pulse,
   input logic [DW-1:0] ctrl_q,
   input logic [DW-1:0] data_q
);

   logic rd_only, wr_only, both_off, both_on;
   assign rd_only  =  ctrl_q[RD_BIT] && !ctrl_q[WR_BIT];
   assign wr_only  = !ctrl_q[RD_BIT] &&  ctrl_q[WR_BIT];
   assign both_off = !ctrl_q[RD_BIT] && !ctrl_q[WR_BIT];
   assign both_on  =  ctrl_q[RD_BIT] &&  ctrl_q[WR_BIT];

   p_scratch_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      both_off |-> !gp_strobe);

   p_rdport_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_only && sel_data && cs && !ior_n) |-> gp_strobe);

   p_rdport_view_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_only && sel_data) |-> (rdata == ext_rdata));

   p_read_keeps_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && !ior_n && iow_n) |=> $stable(data_q));

   p_wrport_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_only && sel_data && cs && !iow_n) |-> gp_strobe);

   p_data_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_pulse && sel_data) |=> (data_q == $past(wdata)));

   p_rsvd_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      both_on |-> !gp_strobe);

   p_strobe_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
      gp_strobe |-> (cs && sel_data && (!ior_n || !iow_n)));

   p_oe_needs_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rd_oe |-> (cs && !ior_n));

endmodule

bind xd_ext_port xd_ext_port_chk #(.DW(DW), .RD_BIT(RD_BIT), .WR_BIT(WR_BIT)) i_chk (
   .clk(clk), .rst_n(rst_n), .cs(cs), .ior_n(ior_n), .iow_n(iow_n),
   .wdata(wdata), .ext_rdata(ext_rdata), .rdata(rdata), .rd_oe(rd_oe),
   .gp_strobe(gp_strobe), .sel_data(sel_data), .wr_pulse(wr_pulse),
   .ctrl_q(ctrl_q), .data_q(data_q)
);

// File: tb/test_xd_ext_port.sv
`timescale 1ns/1ps
module test_xd_ext_port;

   logic       clk = 1'b0;
   logic       rst_n, cs, port_sel, ior_n, iow_n;
   logic [7:0] wdata, ext_rdata, rdata;
   logic       rd_oe, gp_strobe;

   int checks = 0;
   int errors = 0;

   logic [7:0] m_pidx, m_xidx, m_data, m_ctrl;

   always #4 clk = ~clk;

   xd_ext_port i_xd_ext_port (
      .clk(clk), .rst_n(rst_n), .cs(cs), .port_sel(port_sel), .ior_n(ior_n),
      .iow_n(iow_n), .wdata(wdata), .ext_rdata(ext_rdata), .rdata(rdata),
      .rd_oe(rd_oe), .gp_strobe(gp_strobe)
   );

   function automatic logic mdl_sel_data(input logic p);
      return p && (m_pidx == 8'h2F) && (m_xidx == 8'h0A);
   endfunction

   function automatic logic mdl_rd_mode();
      return m_ctrl[3] && !m_ctrl[4];
   endfunction

   function automatic logic mdl_wr_mode();
      return !m_ctrl[3] && m_ctrl[4];
   endfunction

   function automatic logic [7:0] mdl_read(input logic p, input logic [7:0] ext);
      if (!p) return m_pidx;
      if (m_pidx == 8'h2E) return m_xidx;
      if (m_pidx == 8'h2F) begin
         if (m_xidx == 8'h0A) return mdl_rd_mode() ? ext : m_data;
         if (m_xidx == 8'h0B) return m_ctrl;
      end
      return 8'h00;
   endfunction

   task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s rdata actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic check1(input string tag, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
      end
   endtask

   task automatic do_write(input logic p, input logic [7:0] v, input logic en, input string tag);
      logic exp_stb;
      exp_stb = en && mdl_sel_data(p) && mdl_wr_mode();
      @(negedge clk);
      cs = en; port_sel = p; wdata = v; iow_n = 1'b0;
      @(posedge clk); #2;
      check1(tag, "gp_strobe on write", gp_strobe, exp_stb);
      @(posedge clk); #2;
      check1(tag, "rd_oe on write", rd_oe, 1'b0);
      @(negedge clk);
      iow_n = 1'b1; cs = 1'b0;
      if (en) begin
         if (!p) m_pidx = v;
         else if (m_pidx == 8'h2E) m_xidx = v;
         else if (m_pidx == 8'h2F && m_xidx == 8'h0A) m_data = v;
         else if (m_pidx == 8'h2F && m_xidx == 8'h0B) m_ctrl = v;
      end
   endtask

   task automatic do_read(input logic p, input logic [7:0] ext, input string tag);
      @(negedge clk);
      cs = 1'b1; port_sel = p; ext_rdata = ext; ior_n = 1'b0;
      @(posedge clk); #2;
      check8(tag, rdata, mdl_read(p, ext));
      check1(tag, "gp_strobe on read", gp_strobe, mdl_sel_data(p) && mdl_rd_mode());
      check1("R11", "rd_oe on read", rd_oe, 1'b1);
      @(negedge clk);
      ior_n = 1'b1; cs = 1'b0;
      #1 check1("R11", "rd_oe idle", rd_oe, 1'b0);
   endtask

   task automatic pick_ext(input logic [7:0] x);
      do_write(1'b0, 8'h2E, 1'b1, "R2");
      do_write(1'b1, x, 1'b1, "R2");
      do_write(1'b0, 8'h2F, 1'b1, "R2");
   endtask

   task automatic set_ctrl(input logic [7:0] c);
      pick_ext(8'h0B);
      do_write(1'b1, c, 1'b1, "R9");
      pick_ext(8'h0A);
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h1F2E3D4C));
      rst_n = 1'b0; cs = 1'b0; port_sel = 1'b0; ior_n = 1'b1; iow_n = 1'b1;
      wdata = '0; ext_rdata = '0;
      m_pidx = '0; m_xidx = '0; m_data = '0; m_ctrl = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check1("R1", "gp_strobe after reset", gp_strobe, 1'b0);
      check1("R1", "rd_oe after reset", rd_oe, 1'b0);
      do_read(1'b0, 8'hFF, "R1");
      pick_ext(8'h0A);
      do_read(1'b1, 8'hFF, "R1");
      pick_ext(8'h0B);
      do_read(1'b1, 8'hFF, "R1");
      pick_ext(8'h55);
      do_write(1'b1, 8'h77, 1'b1, "R2");
      do_read(1'b1, 8'hAA, "R2");

      pick_ext(8'h0A);
      do_write(1'b1, 8'h5A, 1'b1, "R3");
      do_read(1'b1, 8'hC3, "R3");

      set_ctrl(8'h08);
      do_read(1'b1, 8'hC3, "R4");
      do_read(1'b1, 8'h3E, "R4");
      pick_ext(8'h0B);
      do_read(1'b1, 8'h00, "R8");
      pick_ext(8'h0A);
      set_ctrl(8'h00);
      do_read(1'b1, 8'h99, "R5");

      set_ctrl(8'h10);
      do_write(1'b1, 8'h96, 1'b1, "R6");
      do_read(1'b1, 8'h01, "R6");
      do_write(1'b0, 8'h2F, 1'b1, "R8");

      set_ctrl(8'h18);
      do_write(1'b1, 8'h3C, 1'b1, "R7");
      do_read(1'b1, 8'hF0, "R7");

      set_ctrl(8'hE7);
      pick_ext(8'h0B);
      do_read(1'b1, 8'h00, "R9");
      pick_ext(8'h0A);
      do_write(1'b1, 8'h4B, 1'b1, "R9");
      do_read(1'b1, 8'h12, "R9");

      do_write(1'b1, 8'h11, 1'b0, "R10");
      do_read(1'b1, 8'h22, "R10");
      do_write(1'b0, 8'h00, 1'b0, "R10");
      do_read(1'b0, 8'h22, "R10");

      for (int n = 0; n < 500; n++) begin
         int op;
         logic [7:0] v;
         op = int'($urandom_range(0, 6));
         case (op)
            0: begin
               v = ($urandom_range(0, 3) == 0) ? 8'h2E : (($urandom_range(0, 4) == 0) ? 8'($urandom) : 8'h2F);
               do_write(1'b0, v, 1'b1, "R2");
            end
            1, 2: begin
               if (m_pidx == 8'h2E) begin
                  case ($urandom_range(0, 3))
                     0, 1:    v = 8'h0A;
                     2:       v = 8'h0B;
                     default: v = 8'($urandom);
                  endcase
               end else v = 8'($urandom);
               do_write(1'b1, v, 1'b1, mdl_wr_mode() ? "R6" : "R3");
            end
            3:       do_read(1'b0, 8'($urandom), "R2");
            4, 5:    do_read(1'b1, 8'($urandom), mdl_rd_mode() ? "R4" : "R3");
            default: do_write(1'($urandom), 8'($urandom), 1'b0, "R10");
         endcase
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule